// File: doc/BRIEF.md
# DMA Transfer Submission Register Front-End

This block is the register slave that software uses to hand work to a single-channel DMA engine. Software programs a destination address, a source address, a length word and a flag word into staging registers. It then writes the start register. The front-end tags the staged request with a hardware-assigned 5-bit transfer ID and moves it into a small in-order request queue. From the queue it offers requests to a downstream transfer engine over a valid/ready port.

The engine reports each finished transfer with a one-cycle pulse that carries the ID. The front-end records these completions in a 32-entry bitmap that software reads back. Two interrupt causes exist: start-of-transfer (a staged request was taken into the queue, so the staging slot is free again) and end-of-transfer (a completion arrived). Both are latched as sticky pending bits, cleared by writing ones, and gated by a mask.

The register bus is a plain single-cycle strobe. Writes take effect at the clock edge that samples them. Read data is registered and returned with a valid flag one cycle after the read strobe.

Top module: `dma_submit_regs`

## Requirements
- R1: After reset the next-ID register (0x404) reads 0, start (0x408) reads 0, the interrupt mask (0x080) reads 3 (both causes masked), pending (0x084), done bitmap (0x428) and status (0x430) read 0, and `xfer_valid` and `irq` are 0.
- R2: Writing bit 0 = 1 to start (0x408) while control bit 0 (enable) is 1 and no request is staged captures the staging registers together with the current next ID. The next-ID register then advances by one. Start reads 1 for as long as the request stays staged.
- R3: A start write is ignored (the next ID is unchanged and nothing is staged) while enable is 0, while bit 0 of the written value is 0, or while a request is already staged.
- R4: A staged request moves into the queue on the cycle after it was staged, or later, as soon as the queue (QDEPTH entries) is not full. The queue presents requests on `xfer_*` in submission order, with the flags, source, destination and length that were staged. A request leaves the queue when `xfer_valid` and `xfer_ready` are both high.
- R5: Pending bit 0 (start-of-transfer) is set on the cycle a staged request enters the queue.
- R6: A `done_valid` pulse sets bit `done_id` of the done bitmap and pending bit 1 (end-of-transfer). Submitting a request clears the done bit of the ID it receives; this clear wins over a completion for the same ID in the same cycle.
- R7: Writing the pending register clears every pending bit whose written bit is 1. An event arriving in the same cycle as that write leaves its bit set. Pending bits are otherwise held.
- R8: `irq` is high exactly when some pending bit has its mask bit at 0. The source register (0x088) reads pending AND NOT mask.
- R9: `xfer_valid` is 0 while enable (control bit 0) is 0 or pause (control bit 1) is 1.
- R10: Writing control (0x400) with bit 0 = 0 discards the staged request and every queued request. IDs already assigned are not reused early, and the done bitmap is kept.
- R11: The active-ID register (0x42C) holds the ID of the last request accepted by the engine. Status (0x430) reads bit 0 = queue not empty and bit 1 = request staged.
- R12: IDs are assigned in increasing order modulo 32, so ID 0 follows ID 31.
- R13: A read returns its data on `reg_rdata` with `reg_rvalid` high in the cycle after the read strobe. The data reflects the state before that edge. Unmapped offsets read 0. The flags (0x40C, 3 bits), destination (0x410), source (0x414) and length (0x418, 24 bits) registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| xfer_valid | output | 1 | Request offered to the engine |
| xfer_ready | input | 1 | Engine accepts the offered request |
| xfer_id | output | 5 | Transfer ID of the offered request |
| xfer_flags | output | 3 | Flags: bit 0 cyclic, bit 1 last of packet, bit 2 partial reporting |
| xfer_src | output | 32 | Source address |
| xfer_dst | output | 32 | Destination address |
| xfer_len | output | 24 | Length word as written by software |
| done_valid | input | 1 | Completion pulse from the engine |
| done_id | input | 5 | ID of the completed transfer |
| irq | output | 1 | Interrupt request |

## Verification
The bench pushes the queue to its limit, so that one request sits staged behind a full queue and a further start is dropped. A design that overwrote the staged slot or advanced the ID there would hand out a wrong ID or lose a request. The bench submits enough requests to wrap the ID counter and then checks that the reused ID's done bit was cleared; a stale bit would make software retire a transfer that never ran. Completions and clear-writes are made to land in the same cycle, where a clear that wins loses an end-of-transfer interrupt. An abort issued with requests both staged and queued must leave nothing to deliver once enable is restored.

// File: rtl/dsub_pkg.sv
package dsub_pkg;

    localparam int ID_W   = 5;
    localparam int NIDS   = 1 << ID_W;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 24;
    localparam int FLAG_W = 3;
    localparam int DATA_W = 32;
    localparam int IRQ_N  = 2;

    localparam int IRQ_SOT = 0;
    localparam int IRQ_EOT = 1;

    localparam logic [11:0] OFS_IRQ_MASK = 12'h080;
    localparam logic [11:0] OFS_IRQ_PEND = 12'h084;
    localparam logic [11:0] OFS_IRQ_SRC  = 12'h088;
    localparam logic [11:0] OFS_CTRL     = 12'h400;
    localparam logic [11:0] OFS_NEXT_ID  = 12'h404;
    localparam logic [11:0] OFS_START    = 12'h408;
    localparam logic [11:0] OFS_FLAGS    = 12'h40C;
    localparam logic [11:0] OFS_DST      = 12'h410;
    localparam logic [11:0] OFS_SRC      = 12'h414;
    localparam logic [11:0] OFS_LEN      = 12'h418;
    localparam logic [11:0] OFS_DONE     = 12'h428;
    localparam logic [11:0] OFS_ACTIVE   = 12'h42C;
    localparam logic [11:0] OFS_STATUS   = 12'h430;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [FLAG_W-1:0] flags;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  len;
    } xfer_req_t;

    localparam int REQ_W = $bits(xfer_req_t);

    typedef struct packed {
        logic pause;
        logic enable;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] zext(input logic [DATA_W-1:0] v);
        return v;
    endfunction

endpackage

// File: rtl/dsub_req_fifo.sv
module dsub_req_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    // R4
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R4
    fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/dsub_id_track.sv
module dsub_id_track #(
    parameter int ID_W = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  alloc,
    input  logic                  done_valid,
    input  logic [ID_W-1:0]       done_id,
    output logic [ID_W-1:0]       next_id,
    output logic [(1<<ID_W)-1:0]  done_map
);
    localparam int NIDS = 1 << ID_W;

    logic [NIDS-1:0] set_vec, clr_vec;

    for (genvar k = 0; k < NIDS; k++) begin : g_bit
        assign set_vec[k] = done_valid && (done_id == ID_W'(k));
        assign clr_vec[k] = alloc && (next_id == ID_W'(k));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_id  <= '0;
            done_map <= '0;
        end else begin
            if (alloc) next_id <= next_id + 1'b1;
            done_map <= (done_map | set_vec) & ~clr_vec;
        end
    end

    // R12
    id_advance_chk: assert property (@(posedge clk) disable iff (rst)
        alloc |=> next_id == ID_W'($past(next_id) + 1'b1));
    // R6
    done_set_chk: assert property (@(posedge clk) disable iff (rst)
        (done_valid && !(alloc && next_id == done_id)) |=> done_map[$past(done_id)]);
    // R6
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        alloc |=> !done_map[$past(next_id)]);

endmodule

// File: rtl/dsub_irq.sv
module dsub_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wd,
    input  logic         clr_we,
    input  logic [N-1:0] clr_wd,
    input  logic [N-1:0] set,
    output logic [N-1:0] mask,
    output logic [N-1:0] pend,
    output logic         irq
);
    logic [N-1:0] clr_vec;

    assign clr_vec = clr_we ? clr_wd : '0;
    assign irq     = |(pend & ~mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '1;
            pend <= '0;
        end else begin
            if (mask_we) mask <= mask_wd;
            pend <= (pend & ~clr_vec) | set;
        end
    end

    // R7
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|set) |=> ((pend & $past(set)) == $past(set)));
    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_we && set == '0) |=> pend == $past(pend));

endmodule

// File: rtl/dma_submit_regs.sv
module dma_submit_regs
    import dsub_pkg::*;
#(
    parameter int QDEPTH = 4,
    parameter int RA_W   = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [4:0]        xfer_id,
    output logic [2:0]        xfer_flags,
    output logic [31:0]       xfer_src,
    output logic [31:0]       xfer_dst,
    output logic [23:0]       xfer_len,
    input  logic              done_valid,
    input  logic [4:0]        done_id,
    output logic              irq
);
    ctrl_t             ctrl_q;
    logic [FLAG_W-1:0] flags_q;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [LEN_W-1:0]  len_q;
    logic              staged_q;
    xfer_req_t         staged_req;
    logic [ID_W-1:0]   active_id_q;

    logic              wr, rd, abort, start_ok, push, issue;
    logic              fifo_empty, fifo_full;
    logic [REQ_W-1:0]  fifo_dout;
    xfer_req_t         head;
    logic [ID_W-1:0]   next_id;
    logic [NIDS-1:0]   done_map;
    logic [IRQ_N-1:0]  irq_mask, irq_pend, irq_set;
    logic [31:0]       rd_val;

    assign wr       = reg_en && reg_we;
    assign rd       = reg_en && !reg_we;
    assign abort    = wr && (reg_addr == RA_W'(OFS_CTRL)) && !reg_wdata[0];
    assign start_ok = wr && (reg_addr == RA_W'(OFS_START)) && reg_wdata[0]
                      && ctrl_q.enable && !staged_q;
    assign push     = staged_q && !fifo_full && !abort;
    assign issue    = xfer_valid && xfer_ready;

    assign irq_set[IRQ_SOT] = push;
    assign irq_set[IRQ_EOT] = done_valid;

    dsub_req_fifo #(.DEPTH(QDEPTH), .W(REQ_W)) u_fifo (
        .clk(clk), .rst(rst), .flush(abort),
        .push(push), .din(staged_req),
        .pop(issue), .dout(fifo_dout),
        .empty(fifo_empty), .full(fifo_full)
    );

    dsub_id_track #(.ID_W(ID_W)) u_ids (
        .clk(clk), .rst(rst), .alloc(start_ok),
        .done_valid(done_valid), .done_id(done_id),
        .next_id(next_id), .done_map(done_map)
    );

    dsub_irq #(.N(IRQ_N)) u_irq (
        .clk(clk), .rst(rst),
        .mask_we(wr && reg_addr == RA_W'(OFS_IRQ_MASK)),
        .mask_wd(reg_wdata[IRQ_N-1:0]),
        .clr_we(wr && reg_addr == RA_W'(OFS_IRQ_PEND)),
        .clr_wd(reg_wdata[IRQ_N-1:0]),
        .set(irq_set),
        .mask(irq_mask), .pend(irq_pend), .irq(irq)
    );

    assign head       = xfer_req_t'(fifo_dout);
    assign xfer_valid = !fifo_empty && ctrl_q.enable && !ctrl_q.pause;
    assign xfer_id    = head.id;
    assign xfer_flags = head.flags;
    assign xfer_src   = head.src;
    assign xfer_dst   = head.dst;
    assign xfer_len   = head.len;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            flags_q     <= '0;
            src_q       <= '0;
            dst_q       <= '0;
            len_q       <= '0;
            staged_q    <= 1'b0;
            staged_req  <= '0;
            active_id_q <= '0;
        end else begin
            if (wr) begin
                unique case (reg_addr)
                    RA_W'(OFS_CTRL):  ctrl_q  <= ctrl_t'(reg_wdata[1:0]);
                    RA_W'(OFS_FLAGS): flags_q <= reg_wdata[FLAG_W-1:0];
                    RA_W'(OFS_DST):   dst_q   <= reg_wdata[ADDR_W-1:0];
                    RA_W'(OFS_SRC):   src_q   <= reg_wdata[ADDR_W-1:0];
                    RA_W'(OFS_LEN):   len_q   <= reg_wdata[LEN_W-1:0];
                    default: ;
                endcase
            end
            if (abort) begin
                staged_q <= 1'b0;
            end else if (start_ok) begin
                staged_q   <= 1'b1;
                staged_req <= '{id: next_id, flags: flags_q, src: src_q,
                                dst: dst_q, len: len_q};
            end else if (push) begin
                staged_q <= 1'b0;
            end
            if (issue) active_id_q <= head.id;
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_W'(OFS_IRQ_MASK): rd_val = zext(32'(irq_mask));
            RA_W'(OFS_IRQ_PEND): rd_val = zext(32'(irq_pend));
            RA_W'(OFS_IRQ_SRC):  rd_val = zext(32'(irq_pend & ~irq_mask));
            RA_W'(OFS_CTRL):     rd_val = zext(32'(ctrl_q));
            RA_W'(OFS_NEXT_ID):  rd_val = zext(32'(next_id));
            RA_W'(OFS_START):    rd_val = zext(32'(staged_q));
            RA_W'(OFS_FLAGS):    rd_val = zext(32'(flags_q));
            RA_W'(OFS_DST):      rd_val = zext(32'(dst_q));
            RA_W'(OFS_SRC):      rd_val = zext(32'(src_q));
            RA_W'(OFS_LEN):      rd_val = zext(32'(len_q));
            RA_W'(OFS_DONE):     rd_val = zext(32'(done_map));
            RA_W'(OFS_ACTIVE):   rd_val = zext(32'(active_id_q));
            RA_W'(OFS_STATUS):   rd_val = zext(32'({staged_q, !fifo_empty}));
            default:             rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= rd;
            if (rd) reg_rdata <= rd_val;
        end
    end

    // R2
    start_stage_chk: assert property (@(posedge clk) disable iff (rst)
        start_ok |=> staged_q);
    // R9
    pause_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.enable || ctrl_q.pause) |-> !xfer_valid);
    // R10
    abort_flush_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!staged_q && fifo_empty));
    // R13
    read_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd |=> reg_rvalid);

endmodule

// File: tb/test_dma_submit_regs.sv
module test_dma_submit_regs;
    localparam int QD = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        xfer_valid, xfer_ready = 1'b0;
    logic [4:0]  xfer_id;
    logic [2:0]  xfer_flags;
    logic [31:0] xfer_src, xfer_dst;
    logic [23:0] xfer_len;
    logic        done_valid = 1'b0;
    logic [4:0]  done_id = '0;
    logic        irq;

    always #5 clk = ~clk;

    dma_submit_regs #(.QDEPTH(QD)) i_dma_submit_regs (
        .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
        .xfer_id(xfer_id), .xfer_flags(xfer_flags), .xfer_src(xfer_src),
        .xfer_dst(xfer_dst), .xfer_len(xfer_len), .done_valid(done_valid),
        .done_id(done_id), .irq(irq)
    );

    typedef struct {
        int          id;
        int          flags;
        logic [31:0] src;
        logic [31:0] dst;
        int          len;
    } mreq_t;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    string cur_tag = "R13";

    bit          m_en, m_pause, m_staged, m_rvalid;
    int          m_mask, m_pend, m_next, m_active, m_flags, m_len;
    logic [31:0] m_done, m_src, m_dst, m_rdata;
    mreq_t       m_stg;
    mreq_t       m_q[$];

    function automatic logic [31:0] mread(input logic [11:0] a);
        case (a)
            12'h080: return 32'(m_mask);
            12'h084: return 32'(m_pend);
            12'h088: return 32'(m_pend & ~m_mask & 3);
            12'h400: return {30'd0, m_pause, m_en};
            12'h404: return 32'(m_next);
            12'h408: return {31'd0, m_staged};
            12'h40C: return 32'(m_flags);
            12'h410: return m_dst;
            12'h414: return m_src;
            12'h418: return 32'(m_len);
            12'h428: return m_done;
            12'h42C: return 32'(m_active);
            12'h430: return {30'd0, m_staged, m_q.size() > 0};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_pause = 0; m_staged = 0; m_rvalid = 0;
            m_mask = 3; m_pend = 0; m_next = 0; m_active = 0;
            m_flags = 0; m_len = 0; m_done = '0; m_src = '0; m_dst = '0;
            m_rdata = '0; m_q.delete();
        end else begin
            bit wr, fire, abrt, psh, st;
            int sz, setb;
            wr = reg_en && reg_we;
            m_rvalid = reg_en && !reg_we;
            if (m_rvalid) m_rdata = mread(reg_addr);
            sz   = m_q.size();
            fire = sz > 0 && m_en && !m_pause && xfer_ready;
            abrt = wr && reg_addr == 12'h400 && !reg_wdata[0];
            psh  = m_staged && sz < QD && !abrt;
            st   = wr && reg_addr == 12'h408 && reg_wdata[0] && m_en && !m_staged;
            setb = (psh ? 1 : 0) | (done_valid ? 2 : 0);
            if (fire) begin
                m_active = m_q[0].id;
                void'(m_q.pop_front());
            end
            if (psh) m_q.push_back(m_stg);
            if (abrt) m_q.delete();
            if (done_valid) m_done[done_id] = 1'b1;
            if (abrt) m_staged = 0;
            else if (st) begin
                m_staged = 1;
                m_stg = '{id: m_next, flags: m_flags, src: m_src, dst: m_dst, len: m_len};
                m_done[m_next] = 1'b0;
                m_next = (m_next + 1) % 32;
            end else if (psh) m_staged = 0;
            if (wr) begin
                case (reg_addr)
                    12'h080: m_mask = int'(reg_wdata[1:0]);
                    12'h084: m_pend = m_pend & ~int'(reg_wdata[1:0]);
                    12'h400: begin m_en = reg_wdata[0]; m_pause = reg_wdata[1]; end
                    12'h40C: m_flags = int'(reg_wdata[2:0]);
                    12'h410: m_dst = reg_wdata;
                    12'h414: m_src = reg_wdata;
                    12'h418: m_len = int'(reg_wdata[23:0]);
                    default: ;
                endcase
            end
            m_pend = m_pend | setb;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit mv;
            mv = m_q.size() > 0 && m_en && !m_pause;
            chk("R4 R9 xfer_valid", 64'(xfer_valid), 64'(mv));
            if (mv && xfer_valid) begin
                chk("R2 R12 xfer_id", 64'(xfer_id), 64'(m_q[0].id));
                chk("R4 xfer_payload", {xfer_flags, xfer_len, xfer_src[15:0], xfer_dst[15:0]},
                    {3'(m_q[0].flags), 24'(m_q[0].len), m_q[0].src[15:0], m_q[0].dst[15:0]});
            end
            chk("R8 irq", 64'(irq), 64'((m_pend & ~m_mask & 3) != 0));
            chk("R13 rvalid", 64'(reg_rvalid), 64'(m_rvalid));
            if (m_rvalid) chk({cur_tag, " rdata"}, 64'(reg_rdata), 64'(m_rdata));
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 0; reg_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        reg_en = 1; reg_we = 0; reg_addr = a; cur_tag = tag;
        @(negedge clk);
        reg_en = 0;
    endtask

    task automatic pulse_done(input int id);
        done_valid = 1; done_id = 5'(id);
        @(negedge clk);
        done_valid = 0;
    endtask

    task automatic submit(input int k);
        wr(12'h410, 32'h8000_0000 + 32'(k) * 32'h100);
        wr(12'h414, 32'h1000_0000 + 32'(k) * 32'h40);
        wr(12'h418, 32'(24'h100 + k));
        wr(12'h40C, 32'(k % 8));
        wr(12'h408, 32'd1);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        summary();
    end

    initial begin
        idle(3);
        rst = 0;
        // R1 reset state
        rd(12'h404, "R1 next_id"); rd(12'h408, "R1 start"); rd(12'h080, "R1 mask");
        rd(12'h084, "R1 pend"); rd(12'h428, "R1 done"); rd(12'h430, "R1 status");
        // R13 register readback
        wr(12'h410, 32'hDEAD_BEEF); rd(12'h410, "R13 dst");
        wr(12'h418, 32'hFFFF_FFFF); rd(12'h418, "R13 len");
        rd(12'h7FC, "R13 unmapped");
        // R3 start while disabled is ignored
        wr(12'h408, 32'd1); rd(12'h404, "R3 disabled start"); rd(12'h430, "R3 status");
        wr(12'h400, 32'd1); wr(12'h080, 32'd0);
        // R3 start with bit0 clear is ignored
        wr(12'h408, 32'd2); rd(12'h404, "R3 zero start");
        // R2 R5 first submission, start readback while staged
        submit(0); rd(12'h408, "R2 start busy"); rd(12'h408, "R2 start free");
        rd(12'h084, "R5 sot pend"); rd(12'h404, "R2 next_id");
        // R4 fill queue, leave one staged, extra start ignored
        for (int k = 1; k < 7; k++) submit(k);
        rd(12'h408, "R4 start full"); rd(12'h430, "R11 status full");
        rd(12'h404, "R3 ignored while staged");
        // R4 drain in order
        xfer_ready = 1; idle(10); xfer_ready = 0;
        rd(12'h42C, "R11 active"); rd(12'h430, "R11 status empty");
        // R6 completions
        for (int k = 0; k < 5; k++) pulse_done(k);
        rd(12'h428, "R6 done map"); rd(12'h084, "R6 eot pend"); rd(12'h088, "R8 source");
        // R7 clear collides with completion
        wr(12'h084, 32'd1);
        reg_en = 1; reg_we = 1; reg_addr = 12'h084; reg_wdata = 32'd3;
        done_valid = 1; done_id = 5'd7;
        @(negedge clk);
        reg_en = 0; reg_we = 0; done_valid = 0;
        rd(12'h084, "R7 set wins"); rd(12'h428, "R6 done id7");
        wr(12'h084, 32'd3); rd(12'h084, "R7 cleared");
        // R8 mask gating
        wr(12'h080, 32'd3); pulse_done(8); idle(2);
        rd(12'h088, "R8 masked source");
        wr(12'h080, 32'd1); idle(2); rd(12'h088, "R8 unmasked source");
        wr(12'h084, 32'd3); wr(12'h080, 32'd0);
        // R9 pause
        wr(12'h400, 32'd3); submit(10); submit(11); xfer_ready = 1; idle(4);
        rd(12'h430, "R9 paused status");
        wr(12'h400, 32'd1); idle(4); xfer_ready = 0;
        // R10 abort with staged and queued requests
        for (int k = 0; k < 6; k++) submit(20 + k);
        rd(12'h430, "R10 before abort");
        wr(12'h400, 32'd0); rd(12'h430, "R10 after abort"); rd(12'h408, "R10 start");
        wr(12'h400, 32'd1); xfer_ready = 1; idle(4);
        rd(12'h404, "R10 next_id kept");
        // R12 wrap and R6 reuse clears done bit
        for (int k = 0; k < 30; k++) submit(40 + k);
        idle(6);
        rd(12'h404, "R12 wrapped id"); rd(12'h428, "R6 reuse cleared");
        // mixed traffic, compared every clock
        for (int i = 0; i < 400; i++) begin
            int op;
            xfer_ready = ($urandom % 3) != 0;
            done_valid = ($urandom % 4) == 0;
            done_id = 5'($urandom % 32);
            op = $urandom % 6;
            reg_en = 1;
            case (op)
                0: begin reg_we = 1; reg_addr = 12'h408; reg_wdata = 32'd1; end
                1: begin reg_we = 1; reg_addr = 12'h40C; reg_wdata = $urandom; end
                2: begin reg_we = 1; reg_addr = 12'h084; reg_wdata = $urandom % 4; end
                3: begin reg_we = 0; reg_addr = 12'h428; cur_tag = "R6 mixed done"; end
                4: begin reg_we = 0; reg_addr = 12'h430; cur_tag = "R11 mixed status"; end
                default: begin reg_we = 1; reg_addr = 12'h400; reg_wdata = (i % 97 == 0) ? 32'd0 : 32'd1; end
            endcase
            @(negedge clk);
            reg_en = 0; reg_we = 0; done_valid = 0;
        end
        idle(5);
        summary();
    end

endmodule